// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a system watchdog with its own slow clock domain. Software must service it with a register write before its 8-bit down-counter runs out. If software fails to do so, the block emits a one-cycle pulse that a system reset controller can act on. The host reaches three byte-wide registers over a simple write-only bus: a command register, a divider-select register and a reload register.

Distinct command values do three jobs: they start the timer, reload (service) it, or open the two configuration registers for writing. The counter is clocked through a divide-by-two stage followed by a power-of-two prescaler. A strap pin sampled during reset can make the timer run straight out of reset with no start command.

Once running, the timer cannot be halted by software. A timeout pulse sets the counter back to full scale and returns the configuration to its defaults, so the next timeout follows unless software services the timer.

Top module: `keyed_watchdog`

## Requirements
- R1: A bus write of 0xCC to address 0 while stopped starts the timer with the count at 0xFF. The timeout pulse is then seen in the cycle after clock edge W + P*255, where W is the edge that took the write and P = 2 * 4 * 2^min(s,6) for divider select s. A 0xCC write while running has no effect.
- R2: The timeout output `wdg_reset_pulse` is high for exactly one clock cycle per timeout.
- R3: A write of 0xAA to address 0 while running reloads the count from the reload register (value R) and restarts the divider chain. The timeout then follows at edge W + P*R for R >= 1, and at edge W + 1 for R = 0.
- R4: Writes to address 1 (divider select, bits 2:0) and address 2 (reload value, bits 7:0) are ignored while the configuration is locked. Locked is the state after reset.
- R5: A write of 0x55 to address 0 unlocks the configuration. A later 0xAA write locks it again and also performs the R3 reload.
- R6: Any other value written to address 0 changes neither the lock state nor the timer.
- R7: Divider select values 6 and 7 both divide by 256, so P = 512.
- R8: A new divider select takes effect only at the end of the current prescaler period. The period that is in progress keeps its old length.
- R9: With `hw_start_strap` high during reset, the timer runs from reset release. The first timeout comes at edge E + 2040, where E is the last edge with reset active.
- R10: After a timeout pulse the timer keeps running from 0xFF with divider select 0 and reload 0xFF, and the configuration is locked.
- R11: While stopped, no timeout pulse occurs, and a 0xAA write does not start the timer. Right after reset the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock (its own low-speed domain) |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| hw_start_strap | input | 1 | When high during reset, the timer runs from release |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | 0 command, 1 divider select, 2 reload, 3 unused |
| bus_wdata | input | 8 | Write data |
| wdg_reset_pulse | output | 1 | One-cycle timeout pulse |

## Verification
The embedded properties assume that reset is active from time zero and that the strap changes only while reset is held, since its value is sampled into the run flag during reset. They also assume the bus is already in the watchdog clock domain and presents at most one write per edge. The stimulus changes the strap only inside its reset task and issues every write as a single-edge strobe driven between clock edges. Expected timeout edges are derived from the divider arithmetic of R1 and R3, never read from the design.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   typedef enum logic [1:0] {
      REG_CMD  = 2'd0,
      REG_PSEL = 2'd1,
      REG_RLD  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic start;
      logic feed;
      logic open;
   } key_cmd_t;

endpackage

// File: rtl/kwd_keyregs.sv
module kwd_keyregs
   import kwd_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter int                SEL_W   = 3,
   parameter int                CNT_W   = 8,
   parameter logic [DATA_W-1:0] K_START = 'hCC,
   parameter logic [DATA_W-1:0] K_FEED  = 'hAA,
   parameter logic [DATA_W-1:0] K_OPEN  = 'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wipe,
   output key_cmd_t          cmd,
   output logic              open_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic [CNT_W-1:0]  reload_q
);

   if (SEL_W > DATA_W || CNT_W > DATA_W) begin : g_width_check
      $error("kwd_keyregs: register field wider than bus data");
   end

   logic cmd_hit, psel_hit, rld_hit, other_key;

   always_comb begin
      cmd_hit   = wr_en && (wr_addr == REG_CMD);
      psel_hit  = wr_en && (wr_addr == REG_PSEL) && open_q;
      rld_hit   = wr_en && (wr_addr == REG_RLD) && open_q;
      cmd.start = cmd_hit && (wr_data == K_START);
      cmd.feed  = cmd_hit && (wr_data == K_FEED);
      cmd.open  = cmd_hit && (wr_data == K_OPEN);
      other_key = cmd_hit && !cmd.start && !cmd.feed && !cmd.open;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         open_q   <= 1'b0;
         sel_q    <= '0;
         reload_q <= '1;
      end else begin
         if (cmd.open) begin
            open_q <= 1'b1;
         end else if (cmd.feed) begin
            open_q <= 1'b0;
         end
         if (psel_hit) begin
            sel_q <= wr_data[SEL_W-1:0];
         end
         if (rld_hit) begin
            reload_q <= wr_data[CNT_W-1:0];
         end
      end
   end

   AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_q && !wipe) |=> ($stable(sel_q) && $stable(reload_q)));   // R4
   AST_FEED_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_CMD && wr_data == K_FEED) |=> !open_q);  // R5
   AST_STRAY_KEY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (other_key && !wipe) |=> $stable(open_q));                         // R6

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int SEL_W      = 3,
   parameter int PRE_W      = 8,
   parameter bit HALF_STAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             wipe,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int SHIFT_MAX = PRE_W - 2;

   if (PRE_W < 3) begin : g_pre_check
      $error("kwd_prescaler: PRE_W must be at least 3");
   end

   function automatic logic [PRE_W-1:0] lim_of(input logic [SEL_W-1:0] s);
      int sh;
      sh = (int'(s) > SHIFT_MAX) ? SHIFT_MAX : int'(s);
      return PRE_W'((4 << sh) - 1);
   endfunction

   logic base_tick;

   if (HALF_STAGE) begin : g_half
      logic half_q;
      always_ff @(posedge clk) begin
         if (!rst_n || restart || wipe || !run) begin
            half_q <= 1'b0;
         end else begin
            half_q <= ~half_q;
         end
      end
      assign base_tick = run && half_q;
   end else begin : g_direct
      assign base_tick = run;
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim_q;

   assign tick = base_tick && (pre_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         pre_q <= '0;
         lim_q <= lim_of('0);
      end else if (restart) begin
         pre_q <= '0;
         lim_q <= lim_of(sel);
      end else if (!run) begin
         pre_q <= '0;
      end else if (base_tick) begin
         if (pre_q == lim_q) begin
            pre_q <= '0;
            lim_q <= lim_of(sel);
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run);                                                     // R11
   AST_LIMIT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !wipe && !tick) |=> $stable(lim_q));                  // R8

endmodule

// File: rtl/kwd_downcount.sv
module kwd_downcount #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap,
   input  logic             start_req,
   input  logic             feed_req,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic             running_q,
   output logic             pulse_q,
   output logic             expire,
   output logic             restart
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             feed_hit, start_hit;

   always_comb begin
      feed_hit  = feed_req && running_q;
      start_hit = start_req && !running_q;
      expire    = running_q && ((tick && cnt_q == CNT_ONE) || cnt_q == '0);
      restart   = feed_hit || start_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= strap;
         cnt_q     <= '1;
         pulse_q   <= 1'b0;
      end else begin
         pulse_q <= expire;
         if (start_hit) begin
            running_q <= 1'b1;
         end
         if (expire) begin
            cnt_q <= '1;
         end else if (feed_hit) begin
            cnt_q <= reload;
         end else if (start_hit) begin
            cnt_q <= '1;
         end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);                                             // R2
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      running_q |=> running_q);                                          // R10
   AST_FULL_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> (cnt_q == '1));                                        // R10
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q |-> !pulse_q);                                          // R11
   AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !tick && !feed_req && !expire) |=> $stable(cnt_q));  // R1

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int SEL_W      = 3,
   parameter int PRE_W      = 8,
   parameter int CNT_W      = 8,
   parameter bit HALF_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_start_strap,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              wdg_reset_pulse
);

   if (CNT_W < 2) begin : g_cnt_check
      $error("keyed_watchdog: CNT_W must be at least 2");
   end

   key_cmd_t         cmd;
   logic             open_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] reload_q;
   logic             running, expire, restart, tick;

   kwd_keyregs #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .wr_addr  (bus_addr),
      .wr_data  (bus_wdata),
      .wipe     (expire),
      .cmd      (cmd),
      .open_q   (open_q),
      .sel_q    (sel_q),
      .reload_q (reload_q)
   );

   kwd_prescaler #(
      .SEL_W      (SEL_W),
      .PRE_W      (PRE_W),
      .HALF_STAGE (HALF_STAGE)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running),
      .restart (restart),
      .wipe    (expire),
      .sel     (sel_q),
      .tick    (tick)
   );

   kwd_downcount #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (hw_start_strap),
      .start_req (cmd.start),
      .feed_req  (cmd.feed),
      .tick      (tick),
      .reload    (reload_q),
      .running_q (running),
      .pulse_q   (wdg_reset_pulse),
      .expire    (expire),
      .restart   (restart)
   );

   AST_PULSE_LOCKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_reset_pulse |-> (!open_q && sel_q == '0));                     // R10

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic       pulse;

   keyed_watchdog uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .hw_start_strap  (strap),
      .bus_wr          (we),
      .bus_addr        (addr),
      .bus_wdata       (wdata),
      .wdg_reset_pulse (pulse)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      string tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   int   pulses = 0;
   logic prev = 1'b0;

   // monitor: pops the scoreboard whenever a pulse appears
   always @(negedge clk) begin
      exp_t e;
      if (pulse === 1'b1) begin
         pulses++;
         total++;
         if (q.size() == 0) begin
            bad++;
            $display("FAIL R11 unexpected pulse: actual cycle=%0d expected none", cyc);
         end else begin
            e = q.pop_front();
            if (e.at != cyc) begin
               bad++;
               $display("FAIL %s pulse cycle: actual=%0d expected=%0d", e.tag, cyc, e.at);
            end
         end
      end
      if (prev === 1'b1) begin
         total++;
         if (pulse !== 1'b0) begin
            bad++;
            $display("FAIL R2 pulse width: actual=%b expected=0 at cycle %0d", pulse, cyc);
         end
      end
      prev = pulse;
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d, output int at);
      @(negedge clk);
      we = 1'b1;
      addr = a;
      wdata = d;
      at = cyc + 1;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic expect_at(input int at, input string tag);
      q.push_back('{at, tag});
   endtask

   task automatic drain(input int limit);
      int n;
      n = 0;
      while (q.size() != 0 && n < limit) begin
         @(posedge clk);
         n++;
      end
      if (q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL %s missing pulse: actual=none expected=%0d", q[0].tag, q[0].at);
         q.delete();
      end
   endtask

   task automatic do_reset(input logic s, output int e0);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      repeat (3) @(negedge clk);
      q.delete();
      rst_n = 1'b1;
      e0 = cyc;
      @(negedge clk);
      total++;
      if (pulse !== 1'b0) begin
         bad++;
         $display("FAIL R11 output after reset: actual=%b expected=0", pulse);
      end
   endtask

   initial begin
      #(4 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int es, er, e2, d, e0;

      // R11: stopped timer ignores refresh, stays silent
      do_reset(1'b0, e0);
      wr(2'd0, 8'hAA, d);
      wr(2'd0, 8'h55, d);
      wr(2'd1, 8'd2, d);
      wr(2'd2, 8'd3, d);
      repeat (2500) @(posedge clk);
      total++;
      if (pulses != 0) begin
         bad++;
         $display("FAIL R11 stopped pulses: actual=%0d expected=0", pulses);
      end

      // R1: start with select 2 -> P=32, from 0xFF
      wr(2'd0, 8'hCC, es);
      expect_at(es + 32 * 255, "R1");
      drain(9000);
      // R10 + R4: defaults after pulse, locked reload write ignored
      wr(2'd2, 8'd1, d);
      wr(2'd0, 8'hAA, er);
      expect_at(er + 8 * 255, "R10 R4");
      drain(2500);

      // R3 R5 R6: unlock, stray key, reload 4, relock
      do_reset(1'b0, e0);
      wr(2'd0, 8'hCC, es);
      wr(2'd2, 8'd9, d);
      wr(2'd0, 8'h55, d);
      wr(2'd0, 8'h33, d);
      wr(2'd2, 8'd4, d);
      wr(2'd0, 8'hAA, er);
      wr(2'd2, 8'd10, d);
      wr(2'd0, 8'hAA, e2);
      expect_at(e2 + 4 * 8, "R3 R5 R6");
      drain(200);

      // R7: select 7 saturates at 256 -> P=512
      do_reset(1'b0, e0);
      wr(2'd0, 8'h55, d);
      wr(2'd1, 8'd7, d);
      wr(2'd2, 8'd2, d);
      wr(2'd0, 8'hCC, es);
      wr(2'd0, 8'hAA, er);
      expect_at(er + 2 * 512, "R7");
      drain(1500);

      // R8: select change mid-period applies after the current wrap
      do_reset(1'b0, e0);
      wr(2'd0, 8'hCC, es);
      wr(2'd0, 8'h55, d);
      wr(2'd2, 8'd3, d);
      wr(2'd0, 8'hAA, er);
      wr(2'd0, 8'h55, d);
      wr(2'd1, 8'd1, d);
      expect_at(er + 8 + 16 + 16, "R8");
      drain(200);

      // R3: reload of zero expires on the next edge
      do_reset(1'b0, e0);
      wr(2'd0, 8'hCC, es);
      wr(2'd0, 8'h55, d);
      wr(2'd2, 8'd0, d);
      wr(2'd0, 8'hAA, er);
      expect_at(er + 1, "R3");
      drain(50);

      // R9: strap runs the timer from reset release
      do_reset(1'b1, e0);
      expect_at(e0 + 8 * 255, "R9");
      drain(2500);

      do_reset(1'b0, e0);
      repeat (4) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule